// File: doc/BRIEF.md
# Tri-State Conversion Result Read Port

This block presents a finished 12-bit conversion result to a host data bus. A result register captures the sequencer's output word on the cycle its completion strobe fires and keeps it across any number of reads. The read port is driven by a chip enable, an active-low chip select, a read/convert line, a bus-width select and a byte address. It is also gated by the sequencer's busy flag. Each of the twelve data lines has its own output enable, so an external tri-state pad, or a model of one, can be driven from the pair.

With the bus-width select high, the whole word is driven on all twelve lines. With it low, the word is split into two bytes on the upper eight lines, and the byte address picks which one. Address 0 gives the eight most significant bits. Address 1 gives the four least significant bits in the upper nibble, followed by four zeros. This is a left-justified layout. When the byte address changes, the port drops every enable for one clock before it enables the new byte, so the two bytes never overlap on a shared bus. All control inputs are sampled on the clock, so the output lines follow them one cycle later.

Top module: `result_read_port`

## Requirements
- R1: The enables are nonzero only in the cycle after one in which all four of these hold: read/convert = 1, chip enable = 1, chip select (active low) = 0 and busy = 0. Otherwise every enable is 0.
- R2: When the cycle before had bus-width select = 1 and a valid read, all twelve enables are 1 and data_o equals the stored result. The byte address has no effect, including in the cycle right after it toggles.
- R3: In 8-bit mode with byte address 0, enables [11:4] are 1 and [3:0] are 0, and data_o[11:4] carries result bits [11:4].
- R4: In 8-bit mode with byte address 1, enables [11:4] are 1 and [3:0] are 0. data_o[11:8] carries result bits [3:0] and data_o[7:4] is 0.
- R5: While busy is 1, no data line is enabled in the following cycle.
- R6: In 8-bit mode, a change of the byte address drives all enables to 0 for exactly one clock before the newly selected byte appears.
- R7: Any data line whose enable is 0 reads as 0.
- R8: The stored result is loaded from the sequencer word only on a cycle with the completion strobe high. It is held unchanged across reads and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_ni | input | 1 | Chip select, active low |
| rd_cnv_i | input | 1 | 1 = read, 0 = convert |
| wide_mode_i | input | 1 | 1 = 12-bit bus, 0 = two 8-bit bytes |
| byte_sel_i | input | 1 | Byte address in 8-bit mode |
| busy_i | input | 1 | Conversion in progress from sequencer |
| done_i | input | 1 | Conversion complete strobe |
| result_i | input | 12 | Conversion word from sequencer |
| data_o | output | 12 | Data lines |
| data_oe_o | output | 12 | Per-line output enables |

## Verification
The checker watches every cycle for the following: the four-way read gate, silence while busy, full-width drive, the legal enable patterns, the one-clock gap after a byte-address change in 8-bit mode, zeros on disabled lines, and a fresh result appearing after a strobe. The exact byte contents are shown only by the bench's scenarios, with distinct result words. These include the left-justified low byte with its zero padding, the restored high byte after switching back, and a result that survives repeated reads and is later replaced.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    LM_OFF  = 2'd0,
    LM_FULL = 2'd1,
    LM_HIGH = 2'd2,
    LM_LOW  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/rp_result_hold.sv
module rp_result_hold #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] word_i,
  output logic [RES_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (load_i) word_o <= word_i;
  end
endmodule

// File: rtl/rp_lane_sel.sv
module rp_lane_sel
  import rp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       read_ok_i,
  input  logic       wide_i,
  input  logic       byte_sel_i,
  output lane_mode_e mode_o
);
  logic       sel_q;
  lane_mode_e mode_d;

  // a byte address that differs from last cycle's forces an off cycle
  always_comb begin
    mode_d = LM_OFF;
    if (read_ok_i) begin
      if (wide_i)                   mode_d = LM_FULL;
      else if (byte_sel_i == sel_q) mode_d = byte_sel_i ? LM_LOW : LM_HIGH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      mode_o <= LM_OFF;
    end else begin
      sel_q  <= byte_sel_i;
      mode_o <= mode_d;
    end
  end
endmodule

// File: rtl/rp_lane_drive.sv
module rp_lane_drive
  import rp_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  lane_mode_e       mode_i,
  input  logic [RES_W-1:0] word_i,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] oe_o
);
  localparam int LOW_W   = RES_W - BUS_W;
  localparam int BYTE_LO = RES_W - BUS_W;
  localparam int NIB_LO  = RES_W - LOW_W;

  for (genvar i = 0; i < RES_W; i++) begin : g_lane
    logic low_bit;
    if (i >= NIB_LO) begin : g_nib
      assign low_bit = word_i[i-NIB_LO];
    end else begin : g_pad
      assign low_bit = 1'b0;
    end

    always_comb begin
      data_o[i] = 1'b0;
      oe_o[i]   = 1'b0;
      unique case (mode_i)
        LM_FULL: begin
          data_o[i] = word_i[i];
          oe_o[i]   = 1'b1;
        end
        LM_HIGH: begin
          data_o[i] = (i >= BYTE_LO) ? word_i[i] : 1'b0;
          oe_o[i]   = (i >= BYTE_LO);
        end
        LM_LOW: begin
          data_o[i] = low_bit;
          oe_o[i]   = (i >= BYTE_LO);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/result_read_port.sv
module result_read_port
  import rp_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chip_en_i,
  input  logic             chip_sel_ni,
  input  logic             rd_cnv_i,
  input  logic             wide_mode_i,
  input  logic             byte_sel_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] data_oe_o
);
  logic [RES_W-1:0] word_q;
  lane_mode_e       mode_q;
  logic             read_ok;

  assign read_ok = rd_cnv_i & chip_en_i & ~chip_sel_ni & ~busy_i;

  rp_result_hold #(.RES_W(RES_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done_i),
    .word_i (result_i),
    .word_o (word_q)
  );

  rp_lane_sel i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .read_ok_i  (read_ok),
    .wide_i     (wide_mode_i),
    .byte_sel_i (byte_sel_i),
    .mode_o     (mode_q)
  );

  rp_lane_drive #(.RES_W(RES_W), .BUS_W(BUS_W)) i_drive (
    .mode_i (mode_q),
    .word_i (word_q),
    .data_o (data_o),
    .oe_o   (data_oe_o)
  );
endmodule

// File: rtl/result_read_port_chk.sv
module result_read_port_chk #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_en_i,
  input logic             chip_sel_ni,
  input logic             rd_cnv_i,
  input logic             wide_mode_i,
  input logic             byte_sel_i,
  input logic             busy_i,
  input logic             done_i,
  input logic [RES_W-1:0] result_i,
  input logic [RES_W-1:0] data_o,
  input logic [RES_W-1:0] data_oe_o
);
  localparam logic [RES_W-1:0] BYTE_OE = {{BUS_W{1'b1}}, {(RES_W-BUS_W){1'b0}}};

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0) |-> $past(rd_cnv_i & chip_en_i & ~chip_sel_ni & ~busy_i));

  p_wide_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_cnv_i & chip_en_i & ~chip_sel_ni & ~busy_i & wide_mode_i)
    |-> (data_oe_o == '1));

  p_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> (data_oe_o == '0));

  p_groups_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) || (data_oe_o == '1) || (data_oe_o == BYTE_OE));

  p_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wide_mode_i) && ($past(byte_sel_i) != $past(byte_sel_i, 2)))
    |-> (data_oe_o == '0));

  p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o & ~data_oe_o) == '0);

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_i) && data_oe_o == '1) |-> (data_o == $past(result_i)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '1 && $past(data_oe_o) == '1 && !$past(done_i))
    |-> $stable(data_o));
endmodule

bind result_read_port result_read_port_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) i_chk (.*);

// File: tb/test_result_read_port.sv
module test_result_read_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b0, wide = 1'b1, a0 = 1'b0;
  logic        busy = 1'b0, done = 1'b0;
  logic [11:0] res = '0;
  logic [11:0] dq, oe;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  result_read_port i_result_read_port (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .chip_sel_ni(cs_n),
    .rd_cnv_i(rc), .wide_mode_i(wide), .byte_sel_i(a0), .busy_i(busy),
    .done_i(done), .result_i(res), .data_o(dq), .data_oe_o(oe)
  );

  task automatic check(string req, logic [11:0] exp_oe, logic [11:0] exp_d);
    n_chk++;
    if (oe !== exp_oe || dq !== exp_d) begin
      n_bad++;
      $display("FAIL %s: oe=%h data=%h expected oe=%h data=%h", req, oe, dq, exp_oe, exp_d);
    end
  endtask

  task automatic drive(logic c, logic s, logic r, logic w, logic a, logic b);
    ce = c; cs_n = s; rc = r; wide = w; a0 = a; busy = b;
    @(negedge clk);
  endtask

  task automatic load(logic [11:0] v);
    res = v; done = 1'b1;
    @(negedge clk);
    done = 1'b0; res = ~v;
  endtask

  task automatic t_reset();
    check("R1 reset", 12'h000, 12'h000);
  endtask

  task automatic t_gate();
    load(12'hA5C);
    drive(0, 0, 1, 1, 0, 0); check("R1 ce low", 12'h000, 12'h000);
    drive(1, 1, 1, 1, 0, 0); check("R1 cs high", 12'h000, 12'h000);
    drive(1, 0, 0, 1, 0, 0); check("R1 convert", 12'h000, 12'h000);
    drive(1, 0, 1, 1, 0, 0); check("R1 read", 12'hFFF, 12'hA5C);
  endtask

  task automatic t_busy();
    drive(1, 0, 1, 1, 0, 1); check("R5 busy", 12'h000, 12'h000);
    drive(1, 0, 1, 1, 0, 0); check("R5 busy cleared", 12'hFFF, 12'hA5C);
  endtask

  task automatic t_wide();
    drive(1, 0, 1, 1, 1, 0); check("R2 a0 toggled", 12'hFFF, 12'hA5C);
    drive(1, 0, 1, 1, 0, 0); check("R2 a0 back", 12'hFFF, 12'hA5C);
  endtask

  task automatic t_bytes();
    drive(1, 0, 1, 0, 0, 0); check("R3 high byte", 12'hFF0, 12'hA50);
    drive(1, 0, 1, 0, 1, 0); check("R6 gap to low", 12'h000, 12'h000);
    @(negedge clk);          check("R4 low byte", 12'hFF0, 12'hC00);
    drive(1, 0, 1, 0, 0, 0); check("R6 gap to high", 12'h000, 12'h000);
    @(negedge clk);          check("R3 high again R7", 12'hFF0, 12'hA50);
  endtask

  task automatic t_hold();
    drive(1, 0, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    check("R8 held", 12'hFFF, 12'hA5C);
    drive(0, 1, 1, 1, 0, 0);
    load(12'h3E7);
    drive(1, 0, 1, 1, 0, 0); check("R8 new word", 12'hFFF, 12'h3E7);
    drive(1, 0, 1, 0, 1, 0); check("R6 gap wide to low", 12'h000, 12'h000);
    @(negedge clk);          check("R4 low byte new", 12'hFF0, 12'h700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_busy();
    t_wide();
    t_bytes();
    t_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule